// File: doc/BRIEF.md
# Ready-Gated SPI Host Transaction Sequencer

This block is the host end of a byte-oriented SPI link to a peripheral controller. Each exchange runs inside one chip-select window. The host shifts out a one-byte command, clocks in one status byte, and then moves a burst of data bytes whose length comes from that status byte. Read commands fill a local receive buffer. Write commands drain a local transmit stream whose pending length was loaded beforehand. The SPI clock is generated inside the block from the system clock.

Between transactions the sequencer decides what runs next. A read wins when the peripheral's ready line is high and the local buffer can take a full burst. Failing that, a pending write opens chip select and waits for ready before it sends its command. With neither condition true, the block stays idle and keeps watching ready. A write that needs more bytes than the peripheral accepts is split across as many transactions as it takes. A done pulse marks the moment the last pending byte has gone out.

Top module: `spi_xact_seq`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, spi_mosi is 0, tx_done is 0, rx_avail is 0 and len_err is 0.
- R2: SPI runs in mode 0 (clock idles low, MOSI changes after a falling edge, MISO sampled on the rising edge), MSB first. The host drives 0x00 on MOSI for the status byte and for every read data byte.
- R3: A read transaction sends command 0x81, clocks in one status byte S, then clocks in S data bytes. These bytes are appended to the receive buffer in arrival order and are read out first-in first-out through rx_data, rx_avail and rx_rd. S = 0 moves no data.
- R4: A read status byte above 64 is clamped to 64 data bytes, and len_err goes to 1 and stays at 1 until reset. A status of exactly 64 leaves len_err at 0.
- R5: A write transaction sends command 0x42, clocks in one status byte S, then sends min(S, pending, 64) bytes taken from the transmit stream in order. tx_rd pulses once for each byte taken.
- R6: A write whose status byte is 0 sends no data and deasserts chip select. The pending count is unchanged, so another write transaction follows.
- R7: A write asserts chip select and then waits, with spi_sclk held low, until slv_ready is 1 before sending its command.
- R8: At arbitration a read is chosen whenever slv_ready is 1 and the buffer has at least 64 free bytes, even if a write is pending. With a 128-byte buffer holding more than 64 bytes and nothing pending, slv_ready at 1 starts no transaction.
- R9: The pending count drops by the bytes each burst sends. tx_done is a one-cycle pulse raised only after a burst brings the count to 0. Otherwise another write transaction follows.
- R10: tx_load sets the pending count to tx_len only while the count is 0. While it is nonzero, tx_load is ignored.
- R11: spi_sclk is low whenever spi_cs_n is 1, and spi_cs_n returns to 1 for at least one cycle between transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the peripheral |
| spi_miso | input | 1 | Serial data from the peripheral |
| slv_ready | input | 1 | Peripheral ready line |
| tx_load | input | 1 | Load pending write length |
| tx_len | input | LEN_W | Pending write length to load |
| tx_data | input | 8 | Current byte of the transmit stream |
| tx_rd | output | 1 | Pulse: tx_data was taken, advance the stream |
| tx_done | output | 1 | Pulse: pending count reached zero |
| rx_data | output | 8 | Oldest byte in the receive buffer |
| rx_avail | output | 1 | Receive buffer is not empty |
| rx_rd | input | 1 | Pop the oldest receive byte |
| len_err | output | 1 | Sticky flag: a read status exceeded the burst limit |

## Verification
Several properties are checked on every cycle. The serial clock stays quiet while chip select is high or a write waits for ready. The receive buffer is never pushed when full. The error flag never falls. tx_done appears only as a single pulse with the pending count at zero. A pending count that is nonzero moves only by a single decrement. Other behaviour can only be shown by the bench scenarios with a modelled peripheral. These cover the command and status bytes on the wire, burst lengths under each status value and clamp, byte order through the buffer and from the stream, read-over-write priority, and the full-buffer stall.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    localparam logic [7:0] CMD_WRITE = 8'h42;
    localparam logic [7:0] CMD_READ  = 8'h81;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_RDY,
        ST_CMD,
        ST_STAT,
        ST_DATA,
        ST_END
    } seq_state_e;

    function automatic int unsigned umin(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] din,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] dout
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    logic          busy;
    logic [CW-1:0] ph;
    logic [2:0]    bitn;
    logic [7:0]    sh_out;
    logic [7:0]    sh_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            ph     <= '0;
            bitn   <= '0;
            sh_out <= '0;
            sh_in  <= '0;
            sclk   <= 1'b0;
            done   <= 1'b0;
            dout   <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy   <= 1'b1;
                    sh_out <= din;
                    ph     <= '0;
                    bitn   <= '0;
                    sclk   <= 1'b0;
                end
            end else if (ph == CW'(CLK_DIV - 1)) begin
                ph <= '0;
                if (!sclk) begin
                    sclk  <= 1'b1;
                    sh_in <= {sh_in[6:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bitn == 3'd7) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                        dout <= sh_in;
                    end else begin
                        bitn   <= bitn + 3'd1;
                        sh_out <= {sh_out[6:0], 1'b0};
                    end
                end
            end else begin
                ph <= ph + CW'(1);
            end
        end
    end

    assign mosi = busy & sh_out[7];

endmodule

// File: rtl/spi_rx_buf.sv
module spi_rx_buf #(
    parameter int DEPTH     = 128,
    parameter int BURST_MAX = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [7:0]                 din,
    input  logic                       pop,
    output logic [7:0]                 dout,
    output logic                       avail,
    output logic                       free_ok,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          do_pop;

    assign avail   = (count != '0);
    assign do_pop  = pop && avail;
    assign dout    = mem[rd_ptr];
    assign free_ok = (CW'(DEPTH) - count) >= CW'(BURST_MAX);

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)   wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            if (do_pop) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
            case ({push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
    import spi_seq_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int BURST_MAX = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slv_ready,
    input  logic             free_ok,
    input  logic             tx_load,
    input  logic [LEN_W-1:0] tx_len,
    input  logic [7:0]       tx_data,
    input  logic             sh_done,
    input  logic [7:0]       sh_rx,
    output logic             sh_start,
    output logic [7:0]       sh_tx,
    output logic             cs_n,
    output logic             tx_rd,
    output logic             tx_done,
    output logic             rx_push,
    output logic             len_err,
    output logic [LEN_W-1:0] pend,
    output seq_state_e       state
);
    localparam int BW = $clog2(BURST_MAX + 1);

    logic          is_rd;
    logic [BW-1:0] left;
    logic [BW-1:0] burst_n;
    int unsigned   cap;

    always_comb begin
        cap     = umin(int'(sh_rx), BURST_MAX);
        if (!is_rd) cap = umin(cap, int'(pend));
        burst_n = BW'(cap);
    end

    always_comb begin
        sh_start = 1'b0;
        sh_tx    = 8'h00;
        tx_rd    = 1'b0;
        rx_push  = 1'b0;
        case (state)
            ST_IDLE: if (slv_ready && free_ok) begin
                sh_start = 1'b1;
                sh_tx    = CMD_READ;
            end
            ST_WAIT_RDY: if (slv_ready) begin
                sh_start = 1'b1;
                sh_tx    = CMD_WRITE;
            end
            ST_CMD: sh_start = sh_done;
            ST_STAT: if (sh_done && burst_n != '0) begin
                sh_start = 1'b1;
                sh_tx    = is_rd ? 8'h00 : tx_data;
                tx_rd    = !is_rd;
            end
            ST_DATA: if (sh_done) begin
                rx_push = is_rd;
                if (left != BW'(1)) begin
                    sh_start = 1'b1;
                    sh_tx    = is_rd ? 8'h00 : tx_data;
                    tx_rd    = !is_rd;
                end
            end
            default: ;
        endcase
    end

    assign cs_n = (state == ST_IDLE) || (state == ST_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            is_rd   <= 1'b0;
            left    <= '0;
            pend    <= '0;
            len_err <= 1'b0;
            tx_done <= 1'b0;
        end else begin
            tx_done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (slv_ready && free_ok) begin
                        is_rd <= 1'b1;
                        state <= ST_CMD;
                    end else if (pend != '0) begin
                        is_rd <= 1'b0;
                        state <= ST_WAIT_RDY;
                    end
                end
                ST_WAIT_RDY: if (slv_ready) state <= ST_CMD;
                ST_CMD:      if (sh_done) state <= ST_STAT;
                ST_STAT: if (sh_done) begin
                    left <= burst_n;
                    if (is_rd && int'(sh_rx) > BURST_MAX) len_err <= 1'b1;
                    state <= (burst_n == '0) ? ST_END : ST_DATA;
                end
                ST_DATA: if (sh_done) begin
                    left <= left - BW'(1);
                    if (!is_rd) pend <= pend - LEN_W'(1);
                    if (left == BW'(1)) state <= ST_END;
                end
                ST_END: begin
                    tx_done <= !is_rd && (pend == '0);
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
            if (tx_load && pend == '0) pend <= tx_len;
        end
    end

endmodule

// File: rtl/spi_xact_seq.sv
module spi_xact_seq
    import spi_seq_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int BURST_MAX = 64,
    parameter int BUF_DEPTH = 128,
    parameter int CLK_DIV   = 2
) (
    input  logic             clk,
    input  logic             rst,
    output logic             spi_sclk,
    output logic             spi_cs_n,
    output logic             spi_mosi,
    input  logic             spi_miso,
    input  logic             slv_ready,
    input  logic             tx_load,
    input  logic [LEN_W-1:0] tx_len,
    input  logic [7:0]       tx_data,
    output logic             tx_rd,
    output logic             tx_done,
    output logic [7:0]       rx_data,
    output logic             rx_avail,
    input  logic             rx_rd,
    output logic             len_err
);
    localparam int CNT_W = $clog2(BUF_DEPTH + 1);

    logic             sh_start;
    logic [7:0]       sh_tx;
    logic             sh_done;
    logic [7:0]       sh_rx;
    logic             rx_push;
    logic             free_ok;
    logic [CNT_W-1:0] buf_cnt;
    logic [LEN_W-1:0] pend_cnt;
    seq_state_e       seq_state;

    spi_byte_shift #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .start (sh_start),
        .din   (sh_tx),
        .miso  (spi_miso),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .done  (sh_done),
        .dout  (sh_rx)
    );

    spi_rx_buf #(.DEPTH(BUF_DEPTH), .BURST_MAX(BURST_MAX)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .push    (rx_push),
        .din     (sh_rx),
        .pop     (rx_rd),
        .dout    (rx_data),
        .avail   (rx_avail),
        .free_ok (free_ok),
        .count   (buf_cnt)
    );

    spi_seq_ctrl #(.LEN_W(LEN_W), .BURST_MAX(BURST_MAX)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .slv_ready (slv_ready),
        .free_ok   (free_ok),
        .tx_load   (tx_load),
        .tx_len    (tx_len),
        .tx_data   (tx_data),
        .sh_done   (sh_done),
        .sh_rx     (sh_rx),
        .sh_start  (sh_start),
        .sh_tx     (sh_tx),
        .cs_n      (spi_cs_n),
        .tx_rd     (tx_rd),
        .tx_done   (tx_done),
        .rx_push   (rx_push),
        .len_err   (len_err),
        .pend      (pend_cnt),
        .state     (seq_state)
    );

endmodule

// File: rtl/spi_seq_chk.sv
module spi_seq_chk
    import spi_seq_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int BUF_DEPTH = 128
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           cs_n,
    input logic                           sclk,
    input logic                           tx_done,
    input logic                           len_err,
    input logic                           rx_push,
    input logic [$clog2(BUF_DEPTH+1)-1:0] buf_cnt,
    input logic [LEN_W-1:0]               pend,
    input seq_state_e                     state
);
    // R11
    idle_clk_low_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    // R7
    wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_RDY) |-> (!cs_n && !sclk));

    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !$fell(len_err));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> (int'(buf_cnt) < BUF_DEPTH));

    // R9
    done_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> (pend == '0));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> !tx_done);

    // R10
    load_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (pend != '0) |=> (pend == $past(pend) || pend == $past(pend) - LEN_W'(1)));

endmodule

bind spi_xact_seq spi_seq_chk #(.LEN_W(LEN_W), .BUF_DEPTH(BUF_DEPTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (spi_cs_n),
    .sclk    (spi_sclk),
    .tx_done (tx_done),
    .len_err (len_err),
    .rx_push (rx_push),
    .buf_cnt (buf_cnt),
    .pend    (pend_cnt),
    .state   (seq_state)
);

// File: tb/tb_spi_xact_seq.sv
module tb_spi_xact_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             spi_sclk, spi_cs_n, spi_mosi, spi_miso;
    logic             slv_ready = 1'b0;
    logic             tx_load = 1'b0;
    logic [LEN_W-1:0] tx_len = '0;
    logic [7:0]       tx_data;
    logic             tx_rd, tx_done;
    logic [7:0]       rx_data;
    logic             rx_avail;
    logic             rx_rd = 1'b0;
    logic             len_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_xact_seq dut (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .slv_ready(slv_ready),
        .tx_load(tx_load), .tx_len(tx_len), .tx_data(tx_data), .tx_rd(tx_rd),
        .tx_done(tx_done), .rx_data(rx_data), .rx_avail(rx_avail),
        .rx_rd(rx_rd), .len_err(len_err)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // transmit stream source
    logic [7:0] txmem [256];
    int tx_idx = 0;
    assign tx_data = txmem[tx_idx[7:0]];
    always @(posedge clk) if (tx_rd) tx_idx <= tx_idx + 1;

    int done_cnt = 0;
    always @(posedge clk) if (tx_done) done_cnt <= done_cnt + 1;

    // peripheral model
    int         rd_stat  = 0;
    int         wr_space = 0;
    int         rd_txn   = 0;
    logic [7:0] sl_out   = 8'h00;
    logic [7:0] sl_in    = 8'h00;
    logic [7:0] sl_cmd   = 8'h00;
    logic [7:0] rb;
    int         sl_bit   = 0;
    int         sl_k     = 0;
    int         sl_edges = 0;
    int         txn_bytes = 0;
    int         mosi_bad = 0;
    logic [7:0] wr_log [256];
    int         wn = 0;

    assign spi_miso = sl_out[7];

    function automatic logic [7:0] rdval(input int t, input int j);
        return 8'((t * 37 + j) & 255);
    endfunction

    always @(negedge spi_cs_n) begin
        sl_k = 0; sl_bit = 0; sl_out = 8'h00; sl_edges = 0; txn_bytes = 0; sl_cmd = 8'h00;
    end

    always @(posedge spi_cs_n) if (sl_cmd == 8'h81) rd_txn = rd_txn + 1;

    always @(posedge spi_sclk) begin
        sl_in    = {sl_in[6:0], spi_mosi};
        sl_edges = sl_edges + 1;
    end

    always @(negedge spi_sclk) begin
        if (sl_bit == 7) begin
            sl_bit = 0;
            rb = sl_in;
            if (sl_k == 0) begin
                sl_cmd = rb;
                sl_out = (rb == 8'h81) ? 8'(rd_stat) : (rb == 8'h42) ? 8'(wr_space) : 8'h00;
            end else if (sl_k == 1) begin
                if (rb != 8'h00) mosi_bad = mosi_bad + 1;
                sl_out = (sl_cmd == 8'h81) ? rdval(rd_txn, 0) : 8'h00;
            end else begin
                txn_bytes = txn_bytes + 1;
                if (sl_cmd == 8'h81) begin
                    if (rb != 8'h00) mosi_bad = mosi_bad + 1;
                    sl_out = rdval(rd_txn, sl_k - 1);
                end else begin
                    wr_log[wn[7:0]] = rb;
                    wn = wn + 1;
                    sl_out = 8'h00;
                end
            end
            sl_k = sl_k + 1;
        end else begin
            sl_bit = sl_bit + 1;
            sl_out = {sl_out[6:0], 1'b0};
        end
    end

    // expected receive contents
    logic [7:0] exp_q [512];
    int exp_w = 0;
    int exp_r = 0;

    task automatic expect_read(input int t, input int n);
        for (int j = 0; j < n; j++) begin
            exp_q[exp_w[8:0]] = rdval(t, j);
            exp_w++;
        end
    endtask

    task automatic wait_cs(input logic v);
        @(negedge clk);
        while (spi_cs_n !== v) @(negedge clk);
    endtask

    task automatic load(input int n);
        @(negedge clk);
        tx_load = 1'b1; tx_len = LEN_W'(n);
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    task automatic do_read(input int stat);
        int n;
        n = (stat > 64) ? 64 : stat;
        rd_stat = stat;
        expect_read(rd_txn, n);
        slv_ready = 1'b1;
        wait_cs(1'b0);
        slv_ready = 1'b0;
        wait_cs(1'b1);
        chk(sl_cmd == 8'h81, "R3 read command", int'(sl_cmd), 'h81);
        chk(txn_bytes == n, "R3 read burst length", txn_bytes, n);
        chk(spi_sclk == 1'b0, "R11 sclk low after read", int'(spi_sclk), 0);
    endtask

    task automatic do_wr_txn(input int n);
        wait_cs(1'b0);
        repeat (4) @(negedge clk);
        chk(spi_cs_n == 1'b0 && sl_edges == 0, "R7 wait with cs low and clock idle", sl_edges, 0);
        slv_ready = 1'b1;
        while (spi_sclk !== 1'b1) @(negedge clk);
        slv_ready = 1'b0;
        wait_cs(1'b1);
        chk(sl_cmd == 8'h42, "R5 write command", int'(sl_cmd), 'h42);
        chk(txn_bytes == n, "R5 write burst length", txn_bytes, n);
        chk(spi_sclk == 1'b0, "R11 sclk low after write", int'(spi_sclk), 0);
    endtask

    task automatic drain(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_rd = 1'b0;
            chk(rx_avail == 1'b1, "R3 buffer has byte", int'(rx_avail), 1);
            chk(rx_data == exp_q[exp_r[8:0]], "R3 buffer byte order", int'(rx_data), int'(exp_q[exp_r[8:0]]));
            exp_r++;
            rx_rd = 1'b1;
        end
        @(negedge clk);
        rx_rd = 1'b0;
        @(negedge clk);
        chk(rx_avail == 1'b0, "R3 buffer empty after drain", int'(rx_avail), 0);
    endtask

    task automatic check_written(input string tag);
        chk(wn == tx_idx, {tag, " bytes taken vs sent"}, tx_idx, wn);
        for (int i = 0; i < wn; i++)
            chk(wr_log[i[7:0]] == txmem[i[7:0]], {tag, " write byte order"},
                int'(wr_log[i[7:0]]), int'(txmem[i[7:0]]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int d0;
        for (int i = 0; i < 256; i++) txmem[i] = 8'((i * 7 + 3) & 255);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(spi_cs_n == 1'b1, "R1 cs_n reset", int'(spi_cs_n), 1);
        chk(spi_sclk == 1'b0, "R1 sclk reset", int'(spi_sclk), 0);
        chk(spi_mosi == 1'b0, "R1 mosi reset", int'(spi_mosi), 0);
        chk(tx_done == 1'b0 && len_err == 1'b0, "R1 flags reset", int'(len_err), 0);
        chk(rx_avail == 1'b0, "R1 buffer empty", int'(rx_avail), 0);

        // R3 basic reads, including empty status
        do_read(5);
        drain(5);
        do_read(0);
        chk(rx_avail == 1'b0, "R3 zero status moves nothing", int'(rx_avail), 0);

        // R8 priority: write loaded during a read, ready held high
        wr_space = 4;
        rd_stat  = 2;
        expect_read(rd_txn, 2);
        slv_ready = 1'b1;
        wait_cs(1'b0);
        load(4);
        wait_cs(1'b1);
        expect_read(rd_txn, 2);
        wait_cs(1'b0);
        slv_ready = 1'b0;
        wait_cs(1'b1);
        chk(sl_cmd == 8'h81, "R8 read wins over pending write", int'(sl_cmd), 'h81);
        do_wr_txn(4);
        repeat (3) @(negedge clk);
        chk(done_cnt == 1, "R9 done after single burst", done_cnt, 1);
        drain(4);
        check_written("R5");

        // R5 R9 R10 split write, second load ignored
        wr_space = 4;
        d0 = done_cnt;
        load(10);
        load(50);
        do_wr_txn(4);
        chk(done_cnt == d0, "R9 no done after first burst", done_cnt, d0);
        do_wr_txn(4);
        chk(done_cnt == d0, "R9 no done after second burst", done_cnt, d0);
        do_wr_txn(2);
        repeat (3) @(negedge clk);
        chk(done_cnt == d0 + 1, "R9 done at zero", done_cnt, d0 + 1);
        repeat (20) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R10 ignored load sends nothing", int'(spi_cs_n), 1);
        check_written("R10");

        // R6 zero status write
        wr_space = 0;
        d0 = done_cnt;
        load(5);
        do_wr_txn(0);
        chk(done_cnt == d0, "R6 no done on zero status", done_cnt, d0);
        wr_space = 8;
        do_wr_txn(5);
        repeat (3) @(negedge clk);
        chk(done_cnt == d0 + 1, "R6 pending kept through zero status", done_cnt, d0 + 1);
        check_written("R6");

        // R5 clamp to burst limit
        wr_space = 100;
        d0 = done_cnt;
        load(70);
        do_wr_txn(64);
        do_wr_txn(6);
        repeat (3) @(negedge clk);
        chk(done_cnt == d0 + 1, "R5 done after clamped bursts", done_cnt, d0 + 1);
        check_written("R5");

        // R8 full buffer stalls reads; R4 boundary at 64
        do_read(64);
        chk(len_err == 1'b0, "R4 no error at 64", int'(len_err), 0);
        do_read(64);
        slv_ready = 1'b1;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (spi_cs_n != 1'b1)
                chk(1'b0, "R8 full buffer starts no transaction", int'(spi_cs_n), 1);
        end
        chk(spi_cs_n == 1'b1, "R8 full buffer idle", int'(spi_cs_n), 1);
        slv_ready = 1'b0;
        drain(128);

        // R4 clamp and sticky error
        do_read(70);
        chk(len_err == 1'b1, "R4 error raised", int'(len_err), 1);
        drain(64);
        do_read(3);
        chk(len_err == 1'b1, "R4 error sticky", int'(len_err), 1);
        drain(3);

        chk(mosi_bad == 0, "R2 mosi zero in read phases", mosi_bad, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule